// File: doc/BRIEF.md
# Chain Poll Sequencer

This block is the host-side SPI master for a daisy chain of chips that forward commands to each other. A request names a command byte, a chip address, an optional transmit payload and a transaction mode. The sequencer sends the command frame. In polling mode it then keeps the clock running with all-zero dummy words and checks each returning word for the echoed header. Because the position of the echo depends on how far down the chain the addressed chip sits, there is no fixed response slot. The sequencer searches a window whose size follows from the known chain length. When it finds the header it captures the requested number of reply bytes. If the window runs out first, it reports a missing acknowledge.

Two more modes share the same datapath. Push mode sends a frame and then pads it with four zero bytes per chip, so the frame reaches the far end of the chain. It waits for no echo. Enumeration mode searches a window sized for the longest chain. It derives the chip count from the index of the word where the echo appeared. A nonzero count byte in the reply that disagrees with that index takes precedence.

Top module: `chain_poll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ack_err` and `spi_sclk` are 0 and `spi_cs_n` is 1.
- R2: A frame is sent most significant bit first as: the command byte, the chip byte, then `req_txlen` payload bytes, where payload byte i is taken from `req_txdata[8i+7:8i]`. The frame is zero-filled up to an even byte count, so it is (req_txlen+3) rounded down to even.
- R3: In polling mode (`req_mode` = 0), after the frame the sequencer clocks 2-byte dummy words, numbered from 1, with `spi_mosi` held at 0. It succeeds on the first word whose first byte equals the command and whose second byte equals the chip byte, provided that word's number is at most 2·N+1, where N is `chain_len`.
- R4: When `chain_len` is 0, the polling window is 2·255+1 = 511 words.
- R5: If no word in the window matches, `ack_err` pulses for one cycle, `done` stays low, and exactly the frame plus the whole window has been clocked.
- R6: After a match, exactly `req_rxlen` further bytes are clocked and stored in `rx_data`, with the first byte in bits [7:0]. `done` then pulses.
- R7: A word in which only the command byte matches is not a match, and the search goes on.
- R8: In push mode (`req_mode` = 1), the frame is followed by 4·N zero bytes. `done` then pulses with no search and no error.
- R9: In enumeration mode (`req_mode` = 2), the window is 510 words. If the match is at word k, one more word is read and `enum_count` becomes k/2, rounded down. If the second byte of that extra word is nonzero and differs from k/2, that byte is used instead.
- R10: `busy` is high from the accepted request until the `done` or `ack_err` pulse. A `req_valid` seen while busy is ignored.
- R11: `spi_cs_n` is low for the whole transaction and `spi_sclk` idles low. `spi_mosi` changes while `spi_sclk` is low, and `spi_miso` is sampled on the rising edge of `spi_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_mode | input | 2 | 0 poll, 1 push, 2 enumerate |
| req_cmd | input | 8 | Command byte, also the expected echo byte |
| req_chip | input | 8 | Chip address, also the expected echo byte |
| req_txlen | input | TLW ($clog2(MAX_TX+1)) | Transmit payload byte count, at most MAX_TX |
| req_txdata | input | 8·MAX_TX | Transmit payload, byte i at bits [8i+7:8i] |
| req_rxlen | input | RLW ($clog2(MAX_RX+1)) | Reply bytes to capture after the echo, at most MAX_RX |
| chain_len | input | 8 | Known chip count N, 0 when unknown |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on success |
| ack_err | output | 1 | One-cycle pulse on missing acknowledge |
| rx_data | output | 8·MAX_RX | Captured reply bytes |
| enum_count | output | 8 | Chip count from the last enumeration |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |

## Verification
The assertions assume that `req_txlen` and `req_rxlen` never exceed MAX_TX and MAX_RX. They also assume that the request fields are valid in the cycle `req_valid` is high. The bench only issues requests within those limits and holds the fields steady around the strobe. The slave model in the bench shifts a prepared reply image out on the falling edge of `spi_sclk`. It places the echoed header at chosen word numbers, so that every match, miss and boundary case arises from real serial traffic and never from forced internal state.

// File: rtl/chain_poll_pkg.sv
`timescale 1ns/1ps
package chain_poll_pkg;
   localparam int CHAIN_MAX = 255;
   localparam int ENUM_WORDS = 2 * CHAIN_MAX;

   localparam logic [1:0] MODE_POLL = 2'd0;
   localparam logic [1:0] MODE_PUSH = 2'd1;
   localparam logic [1:0] MODE_ENUM = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FRAME,
      ST_PAD,
      ST_HUNT0,
      ST_HUNT1,
      ST_PAY,
      ST_ECNT
   } seq_state_t;
endpackage

// File: rtl/cps_byte_shifter.sv
`timescale 1ns/1ps
module cps_byte_shifter #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi,
   input  logic       miso
);
   localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [DW-1:0] HLAST = DW'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
   endgenerate

   logic          run;
   logic [DW-1:0] hcnt;
   logic [2:0]    bitn;
   logic [7:0]    tx_sh;
   logic [7:0]    rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         hcnt  <= '0;
         bitn  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
         sclk  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            if (start) begin
               run   <= 1'b1;
               tx_sh <= tx_byte;
               bitn  <= '0;
               hcnt  <= '0;
            end
         end else if (hcnt == HLAST) begin
            hcnt <= '0;
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sh <= {rx_sh[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  run  <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn  <= bitn + 3'd1;
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
         end else begin
            hcnt <= hcnt + DW'(1);
         end
      end
   end

   assign rx_byte = rx_sh;
   assign mosi    = run & tx_sh[7];

   AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !sclk); // R11
   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run && !sclk); // R11
endmodule

// File: rtl/cps_seq_fsm.sv
`timescale 1ns/1ps
module cps_seq_fsm
   import chain_poll_pkg::*;
#(
   parameter int MAX_TX = 6,
   parameter int MAX_RX = 6,
   localparam int TLW = $clog2(MAX_TX + 1),
   localparam int RLW = $clog2(MAX_RX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic [7:0]          req_cmd,
   input  logic [7:0]          req_chip,
   input  logic [TLW-1:0]      req_txlen,
   input  logic [8*MAX_TX-1:0] req_txdata,
   input  logic [RLW-1:0]      req_rxlen,
   input  logic [7:0]          chain_len,
   output logic                busy,
   output logic                done,
   output logic                ack_err,
   output logic [8*MAX_RX-1:0] rx_data,
   output logic [7:0]          enum_count,
   output logic                cs_n,
   output logic                bs_start,
   output logic [7:0]          bs_tx,
   input  logic                bs_done,
   input  logic [7:0]          bs_rx
);
   localparam int CW = 11;
   localparam int WW = 10;

   generate
      if (MAX_TX < 1 || MAX_RX < 1) begin : g_bad_len
         $error("MAX_TX and MAX_RX must be at least 1");
      end
   endgenerate

   seq_state_t          st;
   logic [CW-1:0]       cnt;
   logic [WW-1:0]       wcnt;
   logic [7:0]          first_b;
   logic                kick;
   logic [1:0]          r_mode;
   logic [7:0]          r_cmd, r_chip, r_n;
   logic [TLW-1:0]      r_txlen;
   logic [RLW-1:0]      r_rxlen;
   logic [8*MAX_TX-1:0] r_txdata;

   logic [CW-1:0] flen, pad_last, rx_last;
   logic [WW-1:0] win;
   logic [7:0]    half_k;

   assign flen     = (CW'(r_txlen) + CW'(3)) & ~CW'(1);
   assign pad_last = CW'({r_n, 2'b00}) - CW'(1);
   assign rx_last  = CW'(r_rxlen) - CW'(1);
   assign win      = (r_mode == MODE_ENUM) ? WW'(ENUM_WORDS) :
                     ({1'b0, r_n, 1'b0} + WW'(1) + ((r_n == 8'd0) ? WW'(ENUM_WORDS) : WW'(0)));
   assign half_k   = 8'(wcnt >> 1);

   assign busy     = (st != ST_IDLE);
   assign cs_n     = (st == ST_IDLE);
   assign bs_start = kick;

   always_comb begin
      bs_tx = 8'h00;
      if (st == ST_FRAME) begin
         if (cnt == CW'(0)) bs_tx = r_cmd;
         else if (cnt == CW'(1)) bs_tx = r_chip;
         else begin
            for (int i = 0; i < MAX_TX; i++) begin
               if (cnt == CW'(i + 2) && TLW'(i) < r_txlen) bs_tx = r_txdata[8*i +: 8];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         wcnt       <= '0;
         first_b    <= '0;
         kick       <= 1'b0;
         done       <= 1'b0;
         ack_err    <= 1'b0;
         r_mode     <= '0;
         r_cmd      <= '0;
         r_chip     <= '0;
         r_n        <= '0;
         r_txlen    <= '0;
         r_rxlen    <= '0;
         r_txdata   <= '0;
         rx_data    <= '0;
         enum_count <= '0;
      end else begin
         kick    <= 1'b0;
         done    <= 1'b0;
         ack_err <= 1'b0;
         if (st == ST_IDLE) begin
            if (req_valid) begin
               r_mode   <= req_mode;
               r_cmd    <= req_cmd;
               r_chip   <= req_chip;
               r_n      <= chain_len;
               r_txlen  <= req_txlen;
               r_rxlen  <= req_rxlen;
               r_txdata <= req_txdata;
               rx_data  <= '0;
               cnt      <= '0;
               wcnt     <= '0;
               st       <= ST_FRAME;
               kick     <= 1'b1;
            end
         end else if (bs_done) begin
            kick <= 1'b1;
            unique case (st)
               ST_FRAME: begin
                  if (cnt == flen - CW'(1)) begin
                     cnt <= '0;
                     if (r_mode == MODE_PUSH) begin
                        if (r_n == 8'd0) begin
                           st <= ST_IDLE; done <= 1'b1; kick <= 1'b0;
                        end else st <= ST_PAD;
                     end else begin
                        st   <= ST_HUNT0;
                        wcnt <= WW'(1);
                     end
                  end else cnt <= cnt + CW'(1);
               end
               ST_PAD: begin
                  if (cnt == pad_last) begin
                     st <= ST_IDLE; done <= 1'b1; kick <= 1'b0;
                  end else cnt <= cnt + CW'(1);
               end
               ST_HUNT0: begin
                  first_b <= bs_rx;
                  st      <= ST_HUNT1;
               end
               ST_HUNT1: begin
                  if (first_b == r_cmd && bs_rx == r_chip) begin
                     cnt <= '0;
                     if (r_mode == MODE_ENUM) st <= ST_ECNT;
                     else if (r_rxlen == RLW'(0)) begin
                        st <= ST_IDLE; done <= 1'b1; kick <= 1'b0;
                     end else st <= ST_PAY;
                  end else if (wcnt == win) begin
                     st <= ST_IDLE; ack_err <= 1'b1; kick <= 1'b0;
                  end else begin
                     wcnt <= wcnt + WW'(1);
                     st   <= ST_HUNT0;
                  end
               end
               ST_PAY: begin
                  for (int i = 0; i < MAX_RX; i++) begin
                     if (cnt == CW'(i)) rx_data[8*i +: 8] <= bs_rx;
                  end
                  if (cnt == rx_last) begin
                     st <= ST_IDLE; done <= 1'b1; kick <= 1'b0;
                  end else cnt <= cnt + CW'(1);
               end
               ST_ECNT: begin
                  if (cnt == CW'(0)) cnt <= CW'(1);
                  else begin
                     enum_count <= (bs_rx != 8'd0 && bs_rx != half_k) ? bs_rx : half_k;
                     st <= ST_IDLE; done <= 1'b1; kick <= 1'b0;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && ack_err)); // R5
   AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HUNT1) |-> (wcnt != '0 && wcnt <= win)); // R3
   AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bs_start && st != ST_FRAME) |-> bs_tx == 8'h00); // R3
   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(r_cmd) && $stable(r_mode) && $stable(r_chip)); // R10
   AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || ack_err) |-> !busy); // R10
   AST_PUSH_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |-> r_mode != MODE_PUSH); // R8
endmodule

// File: rtl/chain_poll_seq.sv
`timescale 1ns/1ps
module chain_poll_seq #(
   parameter int MAX_TX = 6,
   parameter int MAX_RX = 6,
   parameter int HALF_DIV = 2,
   localparam int TLW = $clog2(MAX_TX + 1),
   localparam int RLW = $clog2(MAX_RX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic [7:0]          req_cmd,
   input  logic [7:0]          req_chip,
   input  logic [TLW-1:0]      req_txlen,
   input  logic [8*MAX_TX-1:0] req_txdata,
   input  logic [RLW-1:0]      req_rxlen,
   input  logic [7:0]          chain_len,
   output logic                busy,
   output logic                done,
   output logic                ack_err,
   output logic [8*MAX_RX-1:0] rx_data,
   output logic [7:0]          enum_count,
   output logic                spi_sclk,
   output logic                spi_cs_n,
   output logic                spi_mosi,
   input  logic                spi_miso
);
   logic       bs_start, bs_done;
   logic [7:0] bs_tx, bs_rx;

   cps_seq_fsm #(.MAX_TX(MAX_TX), .MAX_RX(MAX_RX)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_mode(req_mode), .req_cmd(req_cmd),
      .req_chip(req_chip), .req_txlen(req_txlen), .req_txdata(req_txdata),
      .req_rxlen(req_rxlen), .chain_len(chain_len),
      .busy(busy), .done(done), .ack_err(ack_err), .rx_data(rx_data),
      .enum_count(enum_count), .cs_n(spi_cs_n),
      .bs_start(bs_start), .bs_tx(bs_tx), .bs_done(bs_done), .bs_rx(bs_rx)
   );

   cps_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(bs_start), .tx_byte(bs_tx),
      .done(bs_done), .rx_byte(bs_rx), .sclk(spi_sclk), .mosi(spi_mosi),
      .miso(spi_miso)
   );

   AST_CS_WITH_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk && !spi_mosi); // R11
endmodule

// File: tb/chain_poll_seq_test.sv
`timescale 1ns/1ps
module chain_poll_seq_test;
   localparam int MTX = 6;
   localparam int MRX = 6;
   localparam int TLW = $clog2(MTX + 1);
   localparam int RLW = $clog2(MRX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_mode = '0;
   logic [7:0] req_cmd = '0, req_chip = '0, chain_len = '0;
   logic [TLW-1:0] req_txlen = '0;
   logic [8*MTX-1:0] req_txdata = '0;
   logic [RLW-1:0] req_rxlen = '0;
   logic busy, done, ack_err, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic [8*MRX-1:0] rx_data;
   logic [7:0] enum_count;

   int n_run = 0, n_fail = 0;
   logic got_done, got_err;

   always #2 clk = ~clk;

   chain_poll_seq #(.MAX_TX(MTX), .MAX_RX(MRX), .HALF_DIV(1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_cmd(req_cmd), .req_chip(req_chip), .req_txlen(req_txlen),
      .req_txdata(req_txdata), .req_rxlen(req_rxlen), .chain_len(chain_len),
      .busy(busy), .done(done), .ack_err(ack_err), .rx_data(rx_data),
      .enum_count(enum_count), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // chain model: reply image shifted out, host bytes recorded
   logic [7:0] reply [0:2047];
   logic [7:0] mo [0:2047];
   logic [7:0] cur = '0;
   int bitidx = 0;
   int nbits = 0;

   assign spi_miso = reply[bitidx[13:3]][3'd7 - bitidx[2:0]];

   always @(negedge spi_sclk or posedge spi_cs_n)
      if (spi_cs_n) bitidx <= 0;
      else bitidx <= bitidx + 1;

   always @(posedge spi_sclk) begin
      cur = {cur[6:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits % 8 == 0) mo[(nbits / 8 - 1) % 2048] = cur;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < 2048; i++) reply[i] = 8'h00;
      nbits = 0;
   endtask

   task automatic put_word(input int f, input int k, input logic [7:0] a, input logic [7:0] b);
      reply[f + 2*(k-1)]     = a;
      reply[f + 2*(k-1) + 1] = b;
   endtask

   task automatic start_req(input logic [1:0] m, input logic [7:0] c, input logic [7:0] ch,
                            input int txl, input logic [8*MTX-1:0] txd, input int rxl,
                            input logic [7:0] n);
      @(negedge clk);
      req_mode = m; req_cmd = c; req_chip = ch; req_txlen = TLW'(txl);
      req_txdata = txd; req_rxlen = RLW'(rxl); chain_len = n; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_end();
      int guard = 0;
      got_done = 1'b0; got_err = 1'b0;
      while (!(done || ack_err) && guard < 60000) begin
         @(negedge clk);
         guard++;
      end
      got_done = done; got_err = ack_err;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "cs_n/sclk", {spi_cs_n, spi_sclk}, 2);
      chk(done == 1'b0 && ack_err == 1'b0, "R1", "done/ack_err", {done, ack_err}, 0);
   endtask

   task automatic t_frame_poll();
      clear_model();
      put_word(6, 5, 8'h0A, 8'h02);
      reply[16] = 8'hA1; reply[17] = 8'hB2; reply[18] = 8'hC3; reply[19] = 8'hD4;
      start_req(2'd0, 8'h0A, 8'h02, 3, 48'h0000_0033_2211, 4, 8'd2);
      wait_end();
      chk(got_done && !got_err, "R3", "done at last window word", {got_done, got_err}, 2);
      chk(nbits / 8 == 20, "R6", "bytes clocked", nbits / 8, 20);
      chk({mo[0], mo[1], mo[2], mo[3], mo[4], mo[5]} == 48'h0A02_1122_3300, "R2", "frame bytes",
          {mo[0], mo[1], mo[2], mo[3], mo[4], mo[5]}, 48'h0A02_1122_3300);
      begin
         logic [7:0] acc = 8'h00;
         for (int i = 6; i < 20; i++) acc = acc | mo[i];
         chk(acc == 8'h00, "R3", "dummy bytes zero", acc, 0);
      end
      chk(rx_data[31:0] == 32'hD4C3_B2A1, "R6", "payload", rx_data[31:0], 32'hD4C3_B2A1);
   endtask

   task automatic t_timeout();
      clear_model();
      put_word(2, 6, 8'h0A, 8'h02);
      start_req(2'd0, 8'h0A, 8'h02, 0, '0, 2, 8'd2);
      wait_end();
      chk(got_err && !got_done, "R5", "ack_err only", {got_done, got_err}, 1);
      chk(nbits / 8 == 12, "R5", "bytes clocked", nbits / 8, 12);
   endtask

   task automatic t_partial();
      clear_model();
      put_word(2, 2, 8'h0A, 8'h05);
      put_word(2, 4, 8'h0A, 8'h03);
      reply[10] = 8'h5E;
      start_req(2'd0, 8'h0A, 8'h03, 0, '0, 1, 8'd3);
      wait_end();
      chk(got_done, "R7", "done", got_done, 1);
      chk(nbits / 8 == 11, "R7", "bytes clocked", nbits / 8, 11);
      chk(rx_data[7:0] == 8'h5E, "R7", "payload", rx_data[7:0], 8'h5E);
   endtask

   task automatic t_unknown();
      clear_model();
      put_word(2, 511, 8'h0A, 8'h04);
      start_req(2'd0, 8'h0A, 8'h04, 0, '0, 0, 8'd0);
      wait_end();
      chk(got_done && !got_err, "R4", "match at word 511", {got_done, got_err}, 2);
      chk(nbits / 8 == 1024, "R4", "bytes clocked", nbits / 8, 1024);
      clear_model();
      put_word(2, 512, 8'h0A, 8'h04);
      start_req(2'd0, 8'h0A, 8'h04, 0, '0, 0, 8'd0);
      wait_end();
      chk(got_err && !got_done, "R4", "word 512 outside", {got_done, got_err}, 1);
      chk(nbits / 8 == 1024, "R4", "bytes on miss", nbits / 8, 1024);
   endtask

   task automatic t_push();
      clear_model();
      put_word(8, 1, 8'h07, 8'h02);
      start_req(2'd1, 8'h07, 8'h02, 6, 48'h0605_0403_0201, 0, 8'd3);
      wait_end();
      chk(got_done && !got_err, "R8", "done", {got_done, got_err}, 2);
      chk(nbits / 8 == 20, "R8", "bytes clocked", nbits / 8, 20);
      chk({mo[0], mo[1], mo[2], mo[7]} == 32'h0702_0106, "R2", "push frame",
          {mo[0], mo[1], mo[2], mo[7]}, 32'h0702_0106);
      begin
         logic [7:0] acc = 8'h00;
         for (int i = 8; i < 20; i++) acc = acc | mo[i];
         chk(acc == 8'h00, "R8", "pad zero", acc, 0);
      end
   endtask

   task automatic t_enum();
      clear_model();
      put_word(4, 6, 8'h01, 8'h00);
      start_req(2'd2, 8'h01, 8'h00, 2, '0, 0, 8'd0);
      wait_end();
      chk(got_done, "R9", "done", got_done, 1);
      chk(enum_count == 8'd3, "R9", "count from index", enum_count, 3);
      chk(nbits / 8 == 18, "R9", "bytes clocked", nbits / 8, 18);
      clear_model();
      put_word(4, 8, 8'h01, 8'h00);
      reply[21] = 8'd9;
      start_req(2'd2, 8'h01, 8'h00, 2, '0, 0, 8'd0);
      wait_end();
      chk(enum_count == 8'd9, "R9", "count byte override", enum_count, 9);
      clear_model();
      put_word(4, 9, 8'h01, 8'h00);
      reply[23] = 8'd4;
      start_req(2'd2, 8'h01, 8'h00, 2, '0, 0, 8'd0);
      wait_end();
      chk(enum_count == 8'd4, "R9", "odd index, agreeing byte", enum_count, 4);
   endtask

   task automatic t_busy();
      clear_model();
      put_word(2, 2, 8'h0A, 8'h01);
      start_req(2'd0, 8'h0A, 8'h01, 0, '0, 0, 8'd1);
      repeat (10) @(negedge clk);
      chk(busy == 1'b1, "R10", "busy mid transfer", busy, 1);
      chk(spi_cs_n == 1'b0, "R11", "cs_n low", spi_cs_n, 0);
      req_mode = 2'd1; req_cmd = 8'h55; req_chip = 8'h07; chain_len = 8'd9; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_end();
      chk(got_done, "R10", "done", got_done, 1);
      repeat (200) @(negedge clk);
      chk(nbits / 8 == 6 && busy == 1'b0, "R10", "bytes after ignored req", nbits / 8, 6);
      chk(mo[0] == 8'h0A, "R10", "command kept", mo[0], 8'h0A);
      chk(spi_sclk == 1'b0 && spi_cs_n == 1'b1, "R11", "idle pins", {spi_sclk, spi_cs_n}, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      clear_model();
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_frame_poll();
      t_timeout();
      t_partial();
      t_push();
      t_enum();
      t_busy();
      t_unknown();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule